// File: doc/BRIEF.md
# I3C Bus Command-Session Tracker

This block sits on the controller side of an I3C bus and follows a single transaction through its bus-level events. These events are a START or repeated START carrying a target address, a byte written by the controller, a byte read from the bus, a controller NACK, and a STOP. From this event stream it keeps four pieces of state:

- whether the current frame is addressed to the broadcast address;
- whether a Common Command Code (CCC) session is open;
- which command code was captured;
- whether dynamic address assignment (the code 8'h07 session) is running.

The block also folds the per-target responses into one bus answer. These responses are the match vector at START, the acknowledge vector on writes, and the read data. The answer is an ACK/NACK result and a read byte, both registered one clock after the event strobe.

The targets are modelled outside the block. Each target presents a match bit for the address on the bus, an acknowledge bit for the byte being written, and a read byte. The tracker returns the following to the targets:

- a selection vector;
- one-cycle STOP and NACK notification pulses;
- an error pulse when the address sequence during dynamic address assignment is illegal.

Top module: `ccc_session_tracker`

## Requirements
- R1: A START whose address equals 7'h7E sets `is_bcast`; a START to any other address clears it, one clock after the strobe.
- R2: A START to 7'h7E while `daa_active` is 0 clears `ccc_active`; a START to any other address leaves `ccc_active` and `ccc_code` unchanged.
- R3: A write while `is_bcast` is 1 and `ccc_active` is 0 captures the byte into `ccc_code` and sets `ccc_active`; any other write leaves `ccc_code` unchanged.
- R4: Capturing code 8'h07 sets `daa_active`; it stays set across every START (broadcast or not) and is cleared only by STOP; a broadcast START while it is set does not clear `ccc_active`.
- R5: For a START, `resp_valid` pulses one clock after the strobe with `bus_ack` = 1 exactly when the address is accepted and at least one bit of `tgt_match` is set; the selection `tgt_sel` becomes `tgt_match` (or 0 if not accepted).
- R6: While `daa_active` is 1, a START to any address other than 7'h7E is not accepted: `tgt_sel` becomes 0, `bus_ack` is 0 and `addr_err` pulses for one clock.
- R7: On a write inside a CCC session (including the write that opens it), `bus_ack` is 0 only if the code has bit 7 set (direct) and a selected target drives its `tgt_ack` bit low; for codes with bit 7 clear it is always 1. On a write outside a CCC session, `bus_ack` is 1 only if at least one target is selected and every selected target acknowledges.
- R8: On a read, `rd_data` becomes the byte of the lowest-index selected target and `bus_ack` is 1; with no target selected `rd_data` is 8'hFF and `bus_ack` is 0.
- R9: STOP clears `is_bcast`, `ccc_active`, `daa_active`, `ccc_code` and `tgt_sel`. It pulses `stop_ntf` with the selection, or with every target bit while `daa_active` was 1.
- R10: A NACK event pulses `nack_ntf` with the current selection for one clock and changes no session state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_start | input | 1 | START / repeated START strobe |
| ev_addr | input | ADDR_W | Address sent with the START |
| ev_wr | input | 1 | Byte-written strobe |
| wr_byte | input | DATA_W | Byte written by the controller |
| ev_rd | input | 1 | Byte-read strobe |
| ev_nack | input | 1 | Controller NACK strobe |
| ev_stop | input | 1 | STOP strobe |
| tgt_match | input | NUM_TGT | Per-target address match for the START |
| tgt_ack | input | NUM_TGT | Per-target acknowledge of the written byte |
| tgt_rdata | input | NUM_TGT*DATA_W | Per-target read byte, target i at bits i*DATA_W |
| resp_valid | output | 1 | Result strobe, one clock after START/write/read |
| bus_ack | output | 1 | Combined ACK (1) / NACK (0), valid with resp_valid |
| rd_data | output | DATA_W | Byte returned by the last read |
| addr_err | output | 1 | Illegal address during dynamic address assignment |
| is_bcast | output | 1 | Current frame is broadcast |
| ccc_active | output | 1 | A command session is open |
| daa_active | output | 1 | Dynamic address assignment in progress |
| ccc_code | output | DATA_W | Captured command code |
| tgt_sel | output | NUM_TGT | Targets taking part in the frame |
| stop_ntf | output | NUM_TGT | STOP notification pulse per target |
| nack_ntf | output | NUM_TGT | NACK notification pulse per target |

## Verification
A wrong session flag shows at the status ports one clock after the event that corrupted it. It also shows in the next write's `bus_ack`. A lost `daa_active` lets a targeted START be accepted without `addr_err`. A stuck `ccc_active` stops the next broadcast write from capturing its code. A wrong selection vector appears at the next read as the wrong byte or a spurious 8'hFF, and at the STOP as a wrong `stop_ntf` pattern. All of these symptoms appear within one event of the fault.

// File: rtl/ccc_trk_pkg.sv
package ccc_trk_pkg;

  typedef enum logic [2:0] {
    EV_IDLE,
    EV_START,
    EV_WRITE,
    EV_READ,
    EV_NACK,
    EV_STOP
  } ev_kind_t;

  function automatic ev_kind_t decode_ev(input logic s, input logic w,
                                         input logic r, input logic n,
                                         input logic p);
    if (p)      return EV_STOP;
    else if (s) return EV_START;
    else if (w) return EV_WRITE;
    else if (r) return EV_READ;
    else if (n) return EV_NACK;
    else        return EV_IDLE;
  endfunction

endpackage

// File: rtl/ccc_flags.sv
module ccc_flags
  import ccc_trk_pkg::*;
#(
  parameter int          ADDR_W     = 7,
  parameter int          DATA_W     = 8,
  parameter logic [6:0]  BCAST_ADDR = 7'h7E,
  parameter logic [7:0]  DAA_CODE   = 8'h07
) (
  input  logic              clk,
  input  logic              rst,
  input  ev_kind_t          ev,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_byte,
  output logic              is_bcast,
  output logic              ccc_active,
  output logic              daa_active,
  output logic [DATA_W-1:0] ccc_code,
  output logic              ccc_now,
  output logic [DATA_W-1:0] code_now
);

  logic addr_is_bcast;
  logic opening;

  assign addr_is_bcast = (addr == ADDR_W'(BCAST_ADDR));
  assign opening       = (ev == EV_WRITE) && is_bcast && !ccc_active;
  assign ccc_now       = ccc_active || opening;
  assign code_now      = opening ? wr_byte : ccc_code;

  always_ff @(posedge clk) begin
    if (rst) begin
      is_bcast   <= 1'b0;
      ccc_active <= 1'b0;
      daa_active <= 1'b0;
      ccc_code   <= '0;
    end else begin
      case (ev)
        EV_START: begin
          is_bcast <= addr_is_bcast;
          if (addr_is_bcast && !daa_active) ccc_active <= 1'b0;
        end
        EV_WRITE: begin
          if (opening) begin
            ccc_active <= 1'b1;
            ccc_code   <= wr_byte;
            if (wr_byte == DATA_W'(DAA_CODE)) daa_active <= 1'b1;
          end
        end
        EV_STOP: begin
          is_bcast   <= 1'b0;
          ccc_active <= 1'b0;
          daa_active <= 1'b0;
          ccc_code   <= '0;
        end
        default: ;
      endcase
    end
  end

  // R4: assignment session implies an open command session
  p_daa_in_ccc_r4: assert property (@(posedge clk) disable iff (rst)
    daa_active |-> ccc_active);

  // R4: only STOP ends the assignment session
  p_daa_holds_r4: assert property (@(posedge clk) disable iff (rst)
    (daa_active && ev != EV_STOP) |=> daa_active);

  // R3: code only moves when a session opens or on STOP
  p_code_stable_r3: assert property (@(posedge clk) disable iff (rst)
    (ccc_active && ev != EV_STOP) |=> $stable(ccc_code));

endmodule

// File: rtl/tgt_select.sv
module tgt_select
  import ccc_trk_pkg::*;
#(
  parameter int         NUM_TGT    = 4,
  parameter int         ADDR_W     = 7,
  parameter logic [6:0] BCAST_ADDR = 7'h7E
) (
  input  logic               clk,
  input  logic               rst,
  input  ev_kind_t           ev,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               daa_active,
  input  logic [NUM_TGT-1:0] tgt_match,
  output logic               addr_ok,
  output logic [NUM_TGT-1:0] tgt_sel,
  output logic [NUM_TGT-1:0] stop_ntf,
  output logic [NUM_TGT-1:0] nack_ntf
);

  assign addr_ok = !daa_active || (addr == ADDR_W'(BCAST_ADDR));

  always_ff @(posedge clk) begin
    if (rst) begin
      tgt_sel  <= '0;
      stop_ntf <= '0;
      nack_ntf <= '0;
    end else begin
      stop_ntf <= '0;
      nack_ntf <= '0;
      case (ev)
        EV_START: tgt_sel <= addr_ok ? tgt_match : '0;
        EV_STOP: begin
          stop_ntf <= daa_active ? {NUM_TGT{1'b1}} : tgt_sel;
          tgt_sel  <= '0;
        end
        EV_NACK: nack_ntf <= tgt_sel;
        default: ;
      endcase
    end
  end

  // R9: notifications never overlap
  p_ntf_excl_r9: assert property (@(posedge clk) disable iff (rst)
    !(|stop_ntf && |nack_ntf));

  // R9: selection empty right after STOP
  p_sel_clear_r9: assert property (@(posedge clk) disable iff (rst)
    (ev == EV_STOP) |=> (tgt_sel == '0));

endmodule

// File: rtl/resp_merge.sv
module resp_merge
  import ccc_trk_pkg::*;
#(
  parameter int NUM_TGT = 4,
  parameter int DATA_W  = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  ev_kind_t                  ev,
  input  logic                      addr_ok,
  input  logic [NUM_TGT-1:0]        tgt_match,
  input  logic [NUM_TGT-1:0]        tgt_sel,
  input  logic [NUM_TGT-1:0]        tgt_ack,
  input  logic [NUM_TGT*DATA_W-1:0] tgt_rdata,
  input  logic                      ccc_now,
  input  logic [DATA_W-1:0]         code_now,
  output logic                      resp_valid,
  output logic                      bus_ack,
  output logic [DATA_W-1:0]         rd_data,
  output logic                      addr_err
);

  localparam int DIRECT_BIT = DATA_W - 1;

  logic [DATA_W-1:0] pick [NUM_TGT+1];
  logic              any_refuse;
  logic              wr_ack;

  assign pick[NUM_TGT] = {DATA_W{1'b1}};
  for (genvar i = NUM_TGT - 1; i >= 0; i--) begin : g_rd_pick
    assign pick[i] = tgt_sel[i] ? tgt_rdata[i*DATA_W +: DATA_W] : pick[i+1];
  end

  assign any_refuse = |(tgt_sel & ~tgt_ack);
  assign wr_ack = ccc_now ? !(code_now[DIRECT_BIT] && any_refuse)
                          : (|tgt_sel && !any_refuse);

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid <= 1'b0;
      bus_ack    <= 1'b0;
      rd_data    <= {DATA_W{1'b1}};
      addr_err   <= 1'b0;
    end else begin
      resp_valid <= 1'b0;
      bus_ack    <= 1'b0;
      addr_err   <= 1'b0;
      case (ev)
        EV_START: begin
          resp_valid <= 1'b1;
          bus_ack    <= addr_ok && |tgt_match;
          addr_err   <= !addr_ok;
        end
        EV_WRITE: begin
          resp_valid <= 1'b1;
          bus_ack    <= wr_ack;
        end
        EV_READ: begin
          resp_valid <= 1'b1;
          bus_ack    <= |tgt_sel;
          rd_data    <= pick[0];
        end
        default: ;
      endcase
    end
  end

  // R8: empty selection reads all ones
  p_rd_idle_ones_r8: assert property (@(posedge clk) disable iff (rst)
    (ev == EV_READ && tgt_sel == '0) |=> (rd_data == {DATA_W{1'b1}} && !bus_ack));

  // R5: ACK only comes with a valid result
  p_ack_needs_valid_r5: assert property (@(posedge clk) disable iff (rst)
    bus_ack |-> resp_valid);

endmodule

// File: rtl/ccc_session_tracker.sv
module ccc_session_tracker
  import ccc_trk_pkg::*;
#(
  parameter int         NUM_TGT    = 4,
  parameter int         ADDR_W     = 7,
  parameter int         DATA_W     = 8,
  parameter logic [6:0] BCAST_ADDR = 7'h7E,
  parameter logic [7:0] DAA_CODE   = 8'h07
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      ev_start,
  input  logic [ADDR_W-1:0]         ev_addr,
  input  logic                      ev_wr,
  input  logic [DATA_W-1:0]         wr_byte,
  input  logic                      ev_rd,
  input  logic                      ev_nack,
  input  logic                      ev_stop,
  input  logic [NUM_TGT-1:0]        tgt_match,
  input  logic [NUM_TGT-1:0]        tgt_ack,
  input  logic [NUM_TGT*DATA_W-1:0] tgt_rdata,
  output logic                      resp_valid,
  output logic                      bus_ack,
  output logic [DATA_W-1:0]         rd_data,
  output logic                      addr_err,
  output logic                      is_bcast,
  output logic                      ccc_active,
  output logic                      daa_active,
  output logic [DATA_W-1:0]         ccc_code,
  output logic [NUM_TGT-1:0]        tgt_sel,
  output logic [NUM_TGT-1:0]        stop_ntf,
  output logic [NUM_TGT-1:0]        nack_ntf
);

  ev_kind_t          ev;
  logic              ccc_now;
  logic [DATA_W-1:0] code_now;
  logic              addr_ok;

  assign ev = decode_ev(ev_start, ev_wr, ev_rd, ev_nack, ev_stop);

  ccc_flags #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .BCAST_ADDR(BCAST_ADDR), .DAA_CODE(DAA_CODE)
  ) u_flags (
    .clk(clk), .rst(rst), .ev(ev), .addr(ev_addr), .wr_byte(wr_byte),
    .is_bcast(is_bcast), .ccc_active(ccc_active), .daa_active(daa_active),
    .ccc_code(ccc_code), .ccc_now(ccc_now), .code_now(code_now)
  );

  tgt_select #(
    .NUM_TGT(NUM_TGT), .ADDR_W(ADDR_W), .BCAST_ADDR(BCAST_ADDR)
  ) u_sel (
    .clk(clk), .rst(rst), .ev(ev), .addr(ev_addr), .daa_active(daa_active),
    .tgt_match(tgt_match), .addr_ok(addr_ok), .tgt_sel(tgt_sel),
    .stop_ntf(stop_ntf), .nack_ntf(nack_ntf)
  );

  resp_merge #(
    .NUM_TGT(NUM_TGT), .DATA_W(DATA_W)
  ) u_resp (
    .clk(clk), .rst(rst), .ev(ev), .addr_ok(addr_ok), .tgt_match(tgt_match),
    .tgt_sel(tgt_sel), .tgt_ack(tgt_ack), .tgt_rdata(tgt_rdata),
    .ccc_now(ccc_now), .code_now(code_now), .resp_valid(resp_valid),
    .bus_ack(bus_ack), .rd_data(rd_data), .addr_err(addr_err)
  );

  // input contract: at most one event per clock
  p_one_event: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ev_start, ev_wr, ev_rd, ev_nack, ev_stop}));

  // R1: broadcast flag follows the START address
  p_bcast_follow_r1: assert property (@(posedge clk) disable iff (rst)
    ev_start |=> (is_bcast == (ev_addr == ADDR_W'(BCAST_ADDR)) || $past(ev_addr) == ADDR_W'(BCAST_ADDR)) && (is_bcast == ($past(ev_addr) == ADDR_W'(BCAST_ADDR))));

  // R5: no match means NACK
  p_nomatch_nack_r5: assert property (@(posedge clk) disable iff (rst)
    (ev_start && tgt_match == '0) |=> (resp_valid && !bus_ack));

  // R6: targeted START during assignment is refused
  p_daa_addr_err_r6: assert property (@(posedge clk) disable iff (rst)
    (ev_start && daa_active && ev_addr != ADDR_W'(BCAST_ADDR)) |=> (addr_err && tgt_sel == '0));

  // R7: non-direct command hides target refusals
  p_bcast_ccc_ack_r7: assert property (@(posedge clk) disable iff (rst)
    (ev_wr && ccc_active && !ccc_code[DATA_W-1]) |=> bus_ack);

  // R9: STOP empties every session flag
  p_stop_clears_r9: assert property (@(posedge clk) disable iff (rst)
    ev_stop |=> (!is_bcast && !ccc_active && !daa_active));

  // R10: NACK leaves the session untouched
  p_nack_keeps_r10: assert property (@(posedge clk) disable iff (rst)
    ev_nack |=> ($stable(ccc_active) && $stable(daa_active) && $stable(tgt_sel)));

endmodule

// File: tb/ccc_session_tracker_test.sv
`timescale 1ns/1ps
module ccc_session_tracker_test;

  localparam int NT = 4;
  localparam int DW = 8;
  localparam logic [6:0] BC = 7'h7E;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ev_start = 0, ev_wr = 0, ev_rd = 0, ev_nack = 0, ev_stop = 0;
  logic [6:0] ev_addr = '0;
  logic [DW-1:0] wr_byte = '0;
  logic [NT-1:0] tgt_match = '0, tgt_ack = '0;
  logic [NT*DW-1:0] tgt_rdata = '0;
  logic resp_valid, bus_ack, addr_err, is_bcast, ccc_active, daa_active;
  logic [DW-1:0] rd_data, ccc_code;
  logic [NT-1:0] tgt_sel, stop_ntf, nack_ntf;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // bench model of the session
  bit m_bc = 0, m_ccc = 0, m_daa = 0;
  logic [DW-1:0] m_code = '0, m_rd = 8'hFF;
  logic [NT-1:0] m_sel = '0;

  always #4 clk = ~clk;

  ccc_session_tracker #(.NUM_TGT(NT)) uut (
    .clk(clk), .rst(rst), .ev_start(ev_start), .ev_addr(ev_addr),
    .ev_wr(ev_wr), .wr_byte(wr_byte), .ev_rd(ev_rd), .ev_nack(ev_nack),
    .ev_stop(ev_stop), .tgt_match(tgt_match), .tgt_ack(tgt_ack),
    .tgt_rdata(tgt_rdata), .resp_valid(resp_valid), .bus_ack(bus_ack),
    .rd_data(rd_data), .addr_err(addr_err), .is_bcast(is_bcast),
    .ccc_active(ccc_active), .daa_active(daa_active), .ccc_code(ccc_code),
    .tgt_sel(tgt_sel), .stop_ntf(stop_ntf), .nack_ntf(nack_ntf)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%0h exp=%0h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic bit f_wr_ack(input bit ccc, input logic [DW-1:0] code,
                                  input logic [NT-1:0] sel, input logic [NT-1:0] ack);
    bit refuse = |(sel & ~ack);
    if (ccc) return !(code[DW-1] && refuse);
    return (sel != 0) && !refuse;
  endfunction

  function automatic logic [DW-1:0] f_rd(input logic [NT-1:0] sel,
                                         input logic [NT*DW-1:0] d);
    for (int i = 0; i < NT; i++)
      if (sel[i]) return d[i*DW +: DW];
    return 8'hFF;
  endfunction

  task automatic check_state();
    chk("R1 is_bcast", is_bcast, m_bc);
    chk("R2 ccc_active", ccc_active, m_ccc);
    chk("R3 ccc_code", ccc_code, m_code);
    chk("R4 daa_active", daa_active, m_daa);
    chk("R5 tgt_sel", tgt_sel, m_sel);
  endtask

  task automatic do_start(input logic [6:0] a, input logic [NT-1:0] m);
    bit ok = !m_daa || (a == BC);
    @(negedge clk);
    ev_start = 1; ev_addr = a; tgt_match = m;
    @(negedge clk);
    ev_start = 0;
    m_bc = (a == BC);
    if (a == BC && !m_daa) m_ccc = 0;
    m_sel = ok ? m : '0;
    chk("R5 start valid", resp_valid, 1);
    chk("R5 start ack", bus_ack, ok && (m != 0));
    chk("R6 addr_err", addr_err, !ok);
    check_state();
  endtask

  task automatic do_write(input logic [DW-1:0] b, input logic [NT-1:0] ak);
    bit open = m_bc && !m_ccc;
    bit cnow = m_ccc || open;
    logic [DW-1:0] code = open ? b : m_code;
    @(negedge clk);
    ev_wr = 1; wr_byte = b; tgt_ack = ak;
    @(negedge clk);
    ev_wr = 0;
    if (open) begin
      m_ccc = 1; m_code = b;
      if (b == 8'h07) m_daa = 1;
    end
    chk("R7 write valid", resp_valid, 1);
    chk("R7 write ack", bus_ack, f_wr_ack(cnow, code, m_sel, ak));
    check_state();
  endtask

  task automatic do_read(input logic [NT*DW-1:0] d);
    @(negedge clk);
    ev_rd = 1; tgt_rdata = d;
    @(negedge clk);
    ev_rd = 0;
    m_rd = f_rd(m_sel, d);
    chk("R8 read data", rd_data, m_rd);
    chk("R8 read ack", bus_ack, m_sel != 0);
    check_state();
  endtask

  task automatic do_nack();
    @(negedge clk);
    ev_nack = 1;
    @(negedge clk);
    ev_nack = 0;
    chk("R10 nack_ntf", nack_ntf, m_sel);
    chk("R10 no result", resp_valid, 0);
    check_state();
  endtask

  task automatic do_stop();
    logic [NT-1:0] exp_ntf = m_daa ? {NT{1'b1}} : m_sel;
    @(negedge clk);
    ev_stop = 1;
    @(negedge clk);
    ev_stop = 0;
    m_bc = 0; m_ccc = 0; m_daa = 0; m_code = '0; m_sel = '0;
    chk("R9 stop_ntf", stop_ntf, exp_ntf);
    check_state();
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    end
    $finish;
  end

  initial begin
    void'($urandom(32'hC3C0_0A11));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // reset state
    check_state();
    chk("R8 reset rd_data", rd_data, 8'hFF);
    chk("R5 reset valid", resp_valid, 0);

    // directed: broadcast non-direct CCC hides refusals (R7), code latch (R3)
    do_start(BC, 4'b1111);
    do_write(8'h01, 4'b0000);
    do_write(8'h55, 4'b0000);
    // direct CCC: refusal surfaces (R7)
    do_start(BC, 4'b0011);
    do_write(8'h8A, 4'b1111);
    do_start(7'h12, 4'b0010);
    do_write(8'h33, 4'b0000);
    do_write(8'h34, 4'b0010);
    do_read({8'hD3, 8'hC2, 8'hB1, 8'hA0});
    do_nack();
    do_stop();
    // no selection read yields FF (R8)
    do_start(7'h20, 4'b0000);
    do_read({8'h11, 8'h22, 8'h33, 8'h44});
    do_write(8'h9C, 4'b1111);
    do_stop();
    // assignment session (R4, R6, R9)
    do_start(BC, 4'b1111);
    do_write(8'h07, 4'b1111);
    do_start(BC, 4'b0110);
    do_read({8'h01, 8'h02, 8'h03, 8'h04});
    do_write(8'h5A, 4'b0000);
    do_start(7'h31, 4'b0001);
    do_start(BC, 4'b0100);
    do_stop();

    // constrained random
    for (int it = 0; it < 3000; it++) begin
      int k = $urandom_range(0, 9);
      logic [6:0] a = ($urandom_range(0, 9) < 5) ? BC : 7'($urandom);
      logic [DW-1:0] b;
      case ($urandom_range(0, 3))
        0: b = 8'h07;
        1: b = 8'h80 | 8'($urandom_range(0, 15));
        default: b = 8'($urandom);
      endcase
      if (k < 3)      do_start(a, 4'($urandom));
      else if (k < 6) do_write(b, 4'($urandom));
      else if (k < 8) do_read(32'($urandom));
      else if (k < 9) do_nack();
      else            do_stop();
    end

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    end
    $finish;
  end

endmodule